// File: doc/BRIEF.md
# Sprite Line Buffer and Serializer

This block holds the pattern data for up to eight sprites that appear on the scanline currently being drawn. It turns that data into one pixel stream per sprite, each placed at the sprite's horizontal position. During the sprite fetch phase of the previous line, the fetch logic fills a staging copy of every slot. A metadata write carries the attribute bits, the X position and an in-use flag. Two pattern writes follow, one for the low bit plane and one for the high bit plane. A line-start strobe then copies all staged slots into the live slots in one cycle.

Each live slot has a small state machine. The states are `SL_IDLE` (nothing loaded since reset), `SL_COUNT` (the X down counter is running), `SL_SHIFT` (pixels are leaving the two plane shift registers) and `SL_SPENT` (all eight pixels have been sent). The transitions are:
- LOAD_NOW: a commit with X = 0 enters `SL_SHIFT` from any state.
- LOAD_WAIT: a commit with X ≠ 0 enters `SL_COUNT` from any state.
- ARRIVE: in `SL_COUNT`, a pixel advance while the counter equals 1 enters `SL_SHIFT`.
- EXHAUST: in `SL_SHIFT`, the eighth pixel advance enters `SL_SPENT`.

The block also contains the combinational generator for the pattern fetch address. It takes the tile index, the fine row and the plane being fetched, and follows the pattern-table select bit and the 8×16 size bit. Choosing between sprites and detecting sprite collisions happen elsewhere.

Top module: `spr_line_unit`

## Requirements
- R1: After reset, every slot reports `slot_active` = 0, pixel 0 and attribute 0.
- R2: Metadata and pattern writes change only the staged copy. The live outputs, including `slot_attr`, do not change until `line_start` is pulsed. Position 0 is valid in the cycle after that pulse.
- R3: A slot committed with X = 0 is active at position 0, right after the commit.
- R4: A slot committed with X > 0 is inactive for the first X pixel advances and becomes active on advance number X. Activity only begins on a clock where `pix_adv` or `line_start` was high.
- R5: While active at column c (0..7, where c = advances − X), the slot pixel is {high-plane bit 7−c, low-plane bit 7−c}. Bit 1 of the pixel is the high plane and bit 0 is the low plane, so the most significant pattern bit is sent first.
- R6: After eight active advances the slot becomes inactive. An inactive slot always outputs pixel 0.
- R7: On a clock where neither `pix_adv` nor `line_start` is high, no slot pixel and no active flag changes.
- R8: A slot staged with `meta_used` = 0 sends pattern zero (transparent) whatever pattern bytes were written to it. Its active window timing is unchanged.
- R9: A `line_start` pulse arriving while slots are still counting or shifting discards their state and restarts from the newly staged values.
- R10: With `ctl_tall` = 0, `fa_addr` = `ctl_tbl_sel`·4096 + tile·16 + plane·8 + (row mod 8).
- R11: With `ctl_tall` = 1, `fa_addr` = tile[0]·4096 + ((tile with bit 0 cleared) + (row ≥ 8 ? 1 : 0))·16 + plane·8 + (row mod 8). In this mode `ctl_tbl_sel` is ignored.
- R12: Each slot's `slot_attr` holds the attribute committed with it for the whole line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_tbl_sel | input | 1 | Pattern table select for 8-pixel sprites |
| ctl_tall | input | 1 | 1 = 16-pixel-tall sprites |
| fa_tile | input | 8 | Tile index for address generation |
| fa_row | input | 4 | Fine row within the sprite |
| fa_plane | input | 1 | 0 = low plane, 1 = high plane |
| fa_addr | output | 13 | Pattern fetch address |
| meta_we | input | 1 | Staged metadata write strobe |
| meta_slot | input | 3 | Slot targeted by the metadata write |
| meta_used | input | 1 | 1 = slot filled by evaluation |
| meta_attr | input | 5 | Attribute bits |
| meta_x | input | 8 | Horizontal position |
| pat_we | input | 1 | Staged pattern write strobe |
| pat_slot | input | 3 | Slot targeted by the pattern write |
| pat_plane | input | 1 | 0 = low plane, 1 = high plane |
| pat_data | input | 8 | Fetched pattern byte |
| line_start | input | 1 | Commit staged slots to live slots |
| pix_adv | input | 1 | One pixel advance |
| slot_pix | output | 16 | Slot i pixel at bits [2i+1:2i] |
| slot_attr | output | 40 | Slot i attribute at bits [5i+4:5i] |
| slot_active | output | 8 | Slot i inside its 8-pixel window |

## Verification
The hardest cases to reach from the ports are the two edges of the line: a slot that must start shifting at position 0, and one at X = 255 whose window runs past the normal line end. A third hard case is a commit that lands while slots are still mid-flight. The stimulus stages a line whose X values include 0, 1, 7, 8, 248, 249 and 255. It advances to position 263, sometimes with idle gaps between advances. It then cuts one line off after 100 pixels with a new commit. The address generator is swept over every combination of tile, row, plane, table bit and size bit.

// File: rtl/spr_pkg.sv
package spr_pkg;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_COUNT = 2'd1,
        SL_SHIFT = 2'd2,
        SL_SPENT = 2'd3
    } slot_state_t;

    localparam int TILE_W = 8;
    localparam int ROW_W  = 4;
    localparam int FINE_W = ROW_W - 1;
    localparam int ADDR_W = 1 + (TILE_W - 1) + 1 + 1 + FINE_W;

endpackage

// File: rtl/spr_fetch_addr.sv
module spr_fetch_addr
    import spr_pkg::*;
(
    input  logic              tbl_sel,
    input  logic              tall,
    input  logic [TILE_W-1:0] tile,
    input  logic [ROW_W-1:0]  row,
    input  logic              plane,
    output logic [ADDR_W-1:0] addr
);

    logic [TILE_W-1:0] tile_eff;
    logic              table_eff;

    always_comb begin
        if (tall) begin
            table_eff = tile[0];
            tile_eff  = {tile[TILE_W-1:1], row[ROW_W-1]};
        end else begin
            table_eff = tbl_sel;
            tile_eff  = tile;
        end
        addr = {table_eff, tile_eff, plane, row[FINE_W-1:0]};
    end

endmodule

// File: rtl/spr_stage.sv
module spr_stage #(
    parameter int N_SLOTS = 8,
    parameter int PAT_W   = 8,
    parameter int ATTR_W  = 5,
    parameter int X_W     = 8,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      meta_we,
    input  logic [SLOT_W-1:0]         meta_slot,
    input  logic                      meta_used,
    input  logic [ATTR_W-1:0]         meta_attr,
    input  logic [X_W-1:0]            meta_x,
    input  logic                      pat_we,
    input  logic [SLOT_W-1:0]         pat_slot,
    input  logic                      pat_plane,
    input  logic [PAT_W-1:0]          pat_data,
    output logic [N_SLOTS*PAT_W-1:0]  st_lo,
    output logic [N_SLOTS*PAT_W-1:0]  st_hi,
    output logic [N_SLOTS*ATTR_W-1:0] st_attr,
    output logic [N_SLOTS*X_W-1:0]    st_x
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_stage
        logic              used_q;
        logic [PAT_W-1:0]  lo_q;
        logic [PAT_W-1:0]  hi_q;
        logic [ATTR_W-1:0] attr_q;
        logic [X_W-1:0]    x_q;
        logic              meta_hit;
        logic              pat_hit;

        assign meta_hit = meta_we && (meta_slot == SLOT_W'(g));
        assign pat_hit  = pat_we && (pat_slot == SLOT_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                used_q <= 1'b0;
                attr_q <= '0;
                x_q    <= '0;
            end else if (meta_hit) begin
                used_q <= meta_used;
                attr_q <= meta_attr;
                x_q    <= meta_x;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (pat_hit) begin
                if (pat_plane) begin
                    hi_q <= pat_data;
                end else begin
                    lo_q <= pat_data;
                end
            end
        end

        // unfilled slots present transparent pattern data at commit
        assign st_lo[g*PAT_W +: PAT_W]    = used_q ? lo_q : '0;
        assign st_hi[g*PAT_W +: PAT_W]    = used_q ? hi_q : '0;
        assign st_attr[g*ATTR_W +: ATTR_W] = attr_q;
        assign st_x[g*X_W +: X_W]          = x_q;
    end

endmodule

// File: rtl/spr_slot.sv
module spr_slot
    import spr_pkg::*;
#(
    parameter int PAT_W  = 8,
    parameter int ATTR_W = 5,
    parameter int X_W    = 8,
    localparam int CW    = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              adv,
    input  logic [PAT_W-1:0]  c_lo,
    input  logic [PAT_W-1:0]  c_hi,
    input  logic [ATTR_W-1:0] c_attr,
    input  logic [X_W-1:0]    c_x,
    output logic [1:0]        pix,
    output logic [ATTR_W-1:0] attr,
    output logic              active
);

    slot_state_t       st_q;
    slot_state_t       st_d;
    logic [X_W-1:0]    wait_q;
    logic [PAT_W-1:0]  lo_q;
    logic [PAT_W-1:0]  hi_q;
    logic [ATTR_W-1:0] attr_q;
    logic [CW-1:0]     sh_q;
    logic              arrive;
    logic              exhaust;

    assign arrive  = (wait_q == X_W'(1));
    assign exhaust = (sh_q == CW'(PAT_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: LOAD_NOW, LOAD_WAIT, ARRIVE, EXHAUST
    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d = (c_x == '0) ? SL_SHIFT : SL_COUNT;
        end else if (adv) begin
            unique case (st_q)
                SL_IDLE:  st_d = SL_IDLE;
                SL_COUNT: st_d = arrive ? SL_SHIFT : SL_COUNT;
                SL_SHIFT: st_d = exhaust ? SL_SPENT : SL_SHIFT;
                SL_SPENT: st_d = SL_SPENT;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            attr_q <= '0;
            sh_q   <= '0;
        end else if (commit) begin
            wait_q <= c_x;
            lo_q   <= c_lo;
            hi_q   <= c_hi;
            attr_q <= c_attr;
            sh_q   <= '0;
        end else if (adv) begin
            unique case (st_q)
                SL_COUNT: wait_q <= wait_q - X_W'(1);
                SL_SHIFT: begin
                    lo_q <= {lo_q[PAT_W-2:0], 1'b0};
                    hi_q <= {hi_q[PAT_W-2:0], 1'b0};
                    sh_q <= sh_q + CW'(1);
                end
                SL_IDLE, SL_SPENT: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pix    = 2'b00;
        active = 1'b0;
        unique case (st_q)
            SL_SHIFT: begin
                pix    = {hi_q[PAT_W-1], lo_q[PAT_W-1]};
                active = 1'b1;
            end
            SL_IDLE, SL_COUNT, SL_SPENT: begin
            end
        endcase
    end

    assign attr = attr_q;

endmodule

// File: rtl/spr_line_unit.sv
module spr_line_unit
    import spr_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int PAT_W   = 8,
    parameter int ATTR_W  = 5,
    parameter int X_W     = 8,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_tbl_sel,
    input  logic                      ctl_tall,
    input  logic [TILE_W-1:0]         fa_tile,
    input  logic [ROW_W-1:0]          fa_row,
    input  logic                      fa_plane,
    output logic [ADDR_W-1:0]         fa_addr,
    input  logic                      meta_we,
    input  logic [SLOT_W-1:0]         meta_slot,
    input  logic                      meta_used,
    input  logic [ATTR_W-1:0]         meta_attr,
    input  logic [X_W-1:0]            meta_x,
    input  logic                      pat_we,
    input  logic [SLOT_W-1:0]         pat_slot,
    input  logic                      pat_plane,
    input  logic [PAT_W-1:0]          pat_data,
    input  logic                      line_start,
    input  logic                      pix_adv,
    output logic [2*N_SLOTS-1:0]      slot_pix,
    output logic [ATTR_W*N_SLOTS-1:0] slot_attr,
    output logic [N_SLOTS-1:0]        slot_active
);

    logic [N_SLOTS*PAT_W-1:0]  st_lo;
    logic [N_SLOTS*PAT_W-1:0]  st_hi;
    logic [N_SLOTS*ATTR_W-1:0] st_attr;
    logic [N_SLOTS*X_W-1:0]    st_x;

    spr_fetch_addr u_addr (
        .tbl_sel (ctl_tbl_sel),
        .tall    (ctl_tall),
        .tile    (fa_tile),
        .row     (fa_row),
        .plane   (fa_plane),
        .addr    (fa_addr)
    );

    spr_stage #(
        .N_SLOTS (N_SLOTS),
        .PAT_W   (PAT_W),
        .ATTR_W  (ATTR_W),
        .X_W     (X_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .meta_we   (meta_we),
        .meta_slot (meta_slot),
        .meta_used (meta_used),
        .meta_attr (meta_attr),
        .meta_x    (meta_x),
        .pat_we    (pat_we),
        .pat_slot  (pat_slot),
        .pat_plane (pat_plane),
        .pat_data  (pat_data),
        .st_lo     (st_lo),
        .st_hi     (st_hi),
        .st_attr   (st_attr),
        .st_x      (st_x)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        spr_slot #(
            .PAT_W  (PAT_W),
            .ATTR_W (ATTR_W),
            .X_W    (X_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (line_start),
            .adv    (pix_adv),
            .c_lo   (st_lo[g*PAT_W +: PAT_W]),
            .c_hi   (st_hi[g*PAT_W +: PAT_W]),
            .c_attr (st_attr[g*ATTR_W +: ATTR_W]),
            .c_x    (st_x[g*X_W +: X_W]),
            .pix    (slot_pix[2*g +: 2]),
            .attr   (slot_attr[g*ATTR_W +: ATTR_W]),
            .active (slot_active[g])
        );
    end

endmodule

// File: rtl/spr_line_unit_chk.sv
module spr_line_unit_chk
    import spr_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int PAT_W   = 8,
    parameter int ATTR_W  = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ctl_tbl_sel,
    input logic                      ctl_tall,
    input logic [TILE_W-1:0]         fa_tile,
    input logic                      fa_plane,
    input logic [ADDR_W-1:0]         fa_addr,
    input logic                      line_start,
    input logic                      pix_adv,
    input logic [2*N_SLOTS-1:0]      slot_pix,
    input logic [ATTR_W*N_SLOTS-1:0] slot_attr,
    input logic [N_SLOTS-1:0]        slot_active
);

    always_comb begin
        if (rst_n) begin
            AST_ADDR_PLANE: assert (fa_addr[FINE_W] == fa_plane); // R10
            AST_ADDR_TALL_TABLE: assert (!ctl_tall || fa_addr[ADDR_W-1] == fa_tile[0]); // R11
            AST_ADDR_SMALL_TABLE: assert (ctl_tall || fa_addr[ADDR_W-1] == ctl_tbl_sel); // R10
        end
    end

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_adv && !line_start) |=> ($stable(slot_pix) && $stable(slot_active))); // R7

    AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(slot_attr)); // R12

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_chk
        logic [4:0] run_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (line_start) begin
                run_q <= '0;
            end else if (pix_adv && slot_active[g] && run_q != 5'd31) begin
                run_q <= run_q + 5'd1;
            end
        end

        AST_QUIET_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_active[g] |-> (slot_pix[2*g +: 2] == 2'b00)); // R6

        AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            run_q <= 5'(PAT_W)); // R6

        AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slot_active[g]) |-> $past(pix_adv || line_start)); // R4
    end

endmodule

bind spr_line_unit spr_line_unit_chk #(
    .N_SLOTS (N_SLOTS),
    .PAT_W   (PAT_W),
    .ATTR_W  (ATTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_tbl_sel (ctl_tbl_sel),
    .ctl_tall    (ctl_tall),
    .fa_tile     (fa_tile),
    .fa_plane    (fa_plane),
    .fa_addr     (fa_addr),
    .line_start  (line_start),
    .pix_adv     (pix_adv),
    .slot_pix    (slot_pix),
    .slot_attr   (slot_attr),
    .slot_active (slot_active)
);

// File: tb/spr_line_unit_tb.sv
module spr_line_unit_tb;

    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_tbl_sel = 1'b0;
    logic        ctl_tall = 1'b0;
    logic [7:0]  fa_tile = '0;
    logic [3:0]  fa_row = '0;
    logic        fa_plane = 1'b0;
    logic [12:0] fa_addr;
    logic        meta_we = 1'b0;
    logic [2:0]  meta_slot = '0;
    logic        meta_used = 1'b0;
    logic [4:0]  meta_attr = '0;
    logic [7:0]  meta_x = '0;
    logic        pat_we = 1'b0;
    logic [2:0]  pat_slot = '0;
    logic        pat_plane = 1'b0;
    logic [7:0]  pat_data = '0;
    logic        line_start = 1'b0;
    logic        pix_adv = 1'b0;
    logic [15:0] slot_pix;
    logic [39:0] slot_attr;
    logic [7:0]  slot_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int cur_x [NS];
    int cur_lo [NS];
    int cur_hi [NS];
    int cur_attr [NS];
    int cur_used [NS];

    always #2 clk = ~clk;

    spr_line_unit u_dut (
        .clk (clk), .rst_n (rst_n),
        .ctl_tbl_sel (ctl_tbl_sel), .ctl_tall (ctl_tall),
        .fa_tile (fa_tile), .fa_row (fa_row), .fa_plane (fa_plane), .fa_addr (fa_addr),
        .meta_we (meta_we), .meta_slot (meta_slot), .meta_used (meta_used),
        .meta_attr (meta_attr), .meta_x (meta_x),
        .pat_we (pat_we), .pat_slot (pat_slot), .pat_plane (pat_plane), .pat_data (pat_data),
        .line_start (line_start), .pix_adv (pix_adv),
        .slot_pix (slot_pix), .slot_attr (slot_attr), .slot_active (slot_active)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gen_x(input int ln, input int i);
        if (ln == 0) begin
            case (i)
                0: return 0;
                1: return 1;
                2: return 7;
                3: return 8;
                4: return 248;
                5: return 249;
                6: return 255;
                default: return 100;
            endcase
        end
        return (ln * 37 + i * 29 + 11) % 256;
    endfunction

    task automatic load_line(input int ln);
        int nx [NS];
        int nlo [NS];
        int nhi [NS];
        int nat [NS];
        int nus [NS];
        for (int i = 0; i < NS; i++) begin
            nx[i]  = gen_x(ln, i);
            nlo[i] = (ln * 53 + i * 17 + 5) % 256;
            nhi[i] = (ln * 91 + i * 41 + 3) % 256;
            nat[i] = (ln * 3 + i * 7 + 1) % 32;
            nus[i] = ((ln + i) % 5 != 4) ? 1 : 0;
            @(negedge clk);
            meta_we = 1'b1; meta_slot = 3'(i); meta_used = nus[i][0];
            meta_attr = 5'(nat[i]); meta_x = 8'(nx[i]);
            @(negedge clk);
            meta_we = 1'b0;
            pat_we = 1'b1; pat_slot = 3'(i); pat_plane = 1'b0; pat_data = 8'(nlo[i]);
            @(negedge clk);
            pat_plane = 1'b1; pat_data = 8'(nhi[i]);
            @(negedge clk);
            pat_we = 1'b0;
        end
        // R2: staging has not reached the outputs yet
        for (int i = 0; i < NS; i++) begin
            check("R2 attr before commit", int'(slot_attr[5*i +: 5]), cur_attr[i]);
        end
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < NS; i++) begin
            cur_x[i] = nx[i]; cur_lo[i] = nlo[i]; cur_hi[i] = nhi[i];
            cur_attr[i] = nat[i]; cur_used[i] = nus[i];
        end
    endtask

    task automatic check_pos(input int p, input bit after_gap);
        for (int i = 0; i < NS; i++) begin
            int col;
            int ea;
            int ep;
            string tag;
            col = p - cur_x[i];
            ea = (col >= 0 && col < 8) ? 1 : 0;
            ep = 0;
            if (ea == 1 && cur_used[i] == 1) begin
                ep = (((cur_hi[i] >> (7 - col)) & 1) << 1) | ((cur_lo[i] >> (7 - col)) & 1);
            end
            if (after_gap) tag = "R7 hold";
            else if (cur_used[i] == 0) tag = "R8 unused slot";
            else if (cur_x[i] == 0 && p == 0) tag = "R3 x zero";
            else if (col < 0) tag = "R4 waiting";
            else if (col >= 8) tag = "R6 spent";
            else tag = "R5 shifting";
            check(tag, int'(slot_active[i]), ea);
            check(tag, int'(slot_pix[2*i +: 2]), ep);
            check("R12 attr", int'(slot_attr[5*i +: 5]), cur_attr[i]);
        end
    endtask

    task automatic run_pixels(input int n, input int gap);
        for (int p = 0; p < n; p++) begin
            check_pos(p, 1'b0);
            if (gap > 0) begin
                repeat (gap) @(negedge clk);
                check_pos(p, 1'b1);
            end
            pix_adv = 1'b1;
            @(negedge clk);
            pix_adv = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            cur_x[i] = 0; cur_lo[i] = 0; cur_hi[i] = 0; cur_attr[i] = 0; cur_used[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < NS; i++) begin
            check("R1 active", int'(slot_active[i]), 0);
            check("R1 pix", int'(slot_pix[2*i +: 2]), 0);
            check("R1 attr", int'(slot_attr[5*i +: 5]), 0);
        end

        // R10 / R11 exhaustive address sweep
        for (int tall = 0; tall < 2; tall++) begin
            for (int tbl = 0; tbl < 2; tbl++) begin
                for (int tile = 0; tile < 256; tile++) begin
                    for (int row = 0; row < 16; row++) begin
                        for (int pl = 0; pl < 2; pl++) begin
                            int exp;
                            ctl_tall = tall[0]; ctl_tbl_sel = tbl[0];
                            fa_tile = 8'(tile); fa_row = 4'(row); fa_plane = pl[0];
                            #1;
                            if (tall == 0) begin
                                exp = tbl * 4096 + tile * 16 + pl * 8 + (row % 8);
                                check("R10 small addr", int'(fa_addr), exp);
                            end else begin
                                exp = (tile % 2) * 4096 + ((tile / 2) * 2 + row / 8) * 16
                                      + pl * 8 + (row % 8);
                                check("R11 tall addr", int'(fa_addr), exp);
                            end
                        end
                    end
                end
            end
        end

        // lines with edge X values and varied advance spacing
        for (int ln = 0; ln < 5; ln++) begin
            load_line(ln);
            run_pixels(264, (ln % 2 == 1) ? 1 : 0);
        end
        // R9: cut a line short with a new commit
        load_line(5);
        run_pixels(100, 0);
        load_line(6);
        run_pixels(264, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule